// File: doc/BRIEF.md
# Four-Channel Serial DMA Controller Register File

This block is the register-mapped control plane of a serial controller with four channels. Software reaches it over a simple 32-bit bus with byte addresses. Through that bus it programs a per-channel ring of buffer descriptors for each direction, and it sets a packed enable mask that carries a transmit bit and a receive bit for each channel. It also turns channels on and off by writing a command word. The command opcodes come in two dialects, and a `chip_mode` input picks one of them.

The DMA engines sit next to this block. They take the exported per-channel current pointers, the enable bits and the channel-active flags. They report finished transfers as single-cycle pulses on `tx_evt` and `rx_evt`. Each pulse sets a sticky pending flag. The flags appear in a shared status word, which also drives a level interrupt. Software clears all pending flags at once by writing anything to the status offset.

Top module: `msc_regfile`

## Requirements
- R1: After reset, every register, pending flag, current pointer and channel-active flag is zero, and `irq` and `bus_rdata` are 0.
- R2: The enable mask is at offset 0x14 and can be written and read back. Bit 2n is the TX enable of channel n and bit 2n+1 is its RX enable; both are exported on `tx_enable[n]` and `rx_enable[n]`. Bits 8 and above read as zero.
- R3: Channel n has a window at 0x100*(n+1). Inside it, offset 0x80 is the TX ring start, 0x84 the TX ring end, 0x88 the RX ring start and 0x8C the RX ring end. Each of these reads back the value last written. Other offsets inside the window read as zero.
- R4: A write to a ring start register also loads that ring's current pointer, which appears on `tx_cur_ptr`/`rx_cur_ptr` slice n the cycle after the write. A write to a ring end register leaves the current pointer unchanged.
- R5: Reading offset 0x0 returns the status word. Bit n is channel n's pending TX flag and bit 4+n is its pending RX flag. Both bits are reported only while mask bit 2n (TX enable) is set. The RX enable bit has no effect on reporting.
- R6: A one-cycle pulse on `tx_evt[n]` or `rx_evt[n]` sets the matching pending flag. The flag stays set until it is cleared.
- R7: Any write to offset 0x0, whatever the data, clears every pending flag of every channel. An event pulse in the same cycle as the clear still sets its flag.
- R8: `irq` is high exactly while at least one status bit is reported.
- R9: A write to offset 0x2C24 is a command. Bits [19:12] hold the opcode and bits [1:0] the channel. With `chip_mode`=0, opcode 0x00 turns the channel on and 0x10 turns it off.
- R10: With `chip_mode`=1, opcode 0x00 turns the channel on, and both 0x30 and 0x50 turn it off. Any opcode not listed for the current mode leaves every channel-active flag unchanged.
- R11: Offset 0x2C2C always reads 0x0000FFFF. The command offset reads as zero.
- R12: A read returns its data on `bus_rdata` one cycle after the request, and `bus_rdata` holds that value until the next read. Unmapped offsets read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus request valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 14 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| chip_mode | input | 1 | Command opcode dialect select |
| tx_evt | input | 4 | Per-channel TX completion pulses |
| rx_evt | input | 4 | Per-channel RX completion pulses |
| chan_on | output | 4 | Per-channel active flags |
| tx_enable | output | 4 | Per-channel TX enable (mask bit 2n) |
| rx_enable | output | 4 | Per-channel RX enable (mask bit 2n+1) |
| tx_cur_ptr | output | 128 | TX current pointers, channel n at [32n+31:32n] |
| rx_cur_ptr | output | 128 | RX current pointers, channel n at [32n+31:32n] |
| irq | output | 1 | Level interrupt |

## Verification
The bench sets pending RX flags while only the RX enable bit of a pair is set. A design that gated reporting with the wrong bit of the pair would then raise `irq`. It sends opcodes that belong to one dialect while the other dialect is selected: 0x30 in mode 0 and 0x10 in mode 1. A decoder that merged the two dialects would then turn the channel off. It also lands an event pulse in the same cycle as a status clear. A design that gave the clear priority would lose that event. Finally, it writes ring end registers and unmapped offsets and then compares the exported current pointers and every readable register. This catches designs that load the current pointer from the wrong register or that decode the address window too loosely.

// File: rtl/msc_pkg.sv
package msc_pkg;
   localparam int unsigned BUS_W        = 32;
   localparam logic [13:0] OFS_STATUS   = 14'h0000;
   localparam logic [13:0] OFS_MASK     = 14'h0014;
   localparam logic [13:0] OFS_CMD      = 14'h2C24;
   localparam logic [13:0] OFS_RSP      = 14'h2C2C;
   localparam logic [31:0] RSP_VALUE    = 32'h0000_FFFF;
   localparam logic [7:0]  LOC_TX_START = 8'h80;
   localparam logic [7:0]  LOC_TX_END   = 8'h84;
   localparam logic [7:0]  LOC_RX_START = 8'h88;
   localparam logic [7:0]  LOC_RX_END   = 8'h8C;
   localparam int unsigned RX_STAT_BASE = 4;

   typedef enum logic [1:0] {
      CMD_KEEP = 2'd0,
      CMD_ON   = 2'd1,
      CMD_OFF  = 2'd2
   } cmd_act_e;

   function automatic cmd_act_e decode_opcode(input logic mode, input logic [7:0] op);
      cmd_act_e act;
      act = CMD_KEEP;
      if (op == 8'h00) act = CMD_ON;
      else if (!mode && op == 8'h10) act = CMD_OFF;
      else if (mode && (op == 8'h30 || op == 8'h50)) act = CMD_OFF;
      return act;
   endfunction
endpackage

// File: rtl/msc_chan_regs.sv
module msc_chan_regs #(
   parameter int unsigned PTR_W  = 32,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              win_hit,
   input  logic              wr_en,
   input  logic [7:0]        loc_ofs,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_data,
   output logic [PTR_W-1:0]  tx_cur,
   output logic [PTR_W-1:0]  rx_cur
);
   import msc_pkg::*;

   logic [PTR_W-1:0] tx_start_q, tx_end_q, rx_start_q, rx_end_q;
   logic [PTR_W-1:0] tx_cur_q, rx_cur_q;
   logic             wr_hit;

   assign wr_hit = win_hit && wr_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_start_q <= '0;
         tx_end_q   <= '0;
         rx_start_q <= '0;
         rx_end_q   <= '0;
         tx_cur_q   <= '0;
         rx_cur_q   <= '0;
      end else if (wr_hit) begin
         unique case (loc_ofs)
            LOC_TX_START: begin
               tx_start_q <= wdata[PTR_W-1:0];
               tx_cur_q   <= wdata[PTR_W-1:0];
            end
            LOC_TX_END:   tx_end_q <= wdata[PTR_W-1:0];
            LOC_RX_START: begin
               rx_start_q <= wdata[PTR_W-1:0];
               rx_cur_q   <= wdata[PTR_W-1:0];
            end
            LOC_RX_END:   rx_end_q <= wdata[PTR_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      rd_data = '0;
      unique case (loc_ofs)
         LOC_TX_START: rd_data = DATA_W'(tx_start_q);
         LOC_TX_END:   rd_data = DATA_W'(tx_end_q);
         LOC_RX_START: rd_data = DATA_W'(rx_start_q);
         LOC_RX_END:   rd_data = DATA_W'(rx_end_q);
         default:      rd_data = '0;
      endcase
   end

   assign tx_cur = tx_cur_q;
   assign rx_cur = rx_cur_q;
endmodule

// File: rtl/msc_cmd_ctrl.sv
module msc_cmd_ctrl #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_we,
   input  logic [DATA_W-1:0] cmd_word,
   input  logic              chip_mode,
   output logic [NUM_CH-1:0] chan_on
);
   import msc_pkg::*;

   cmd_act_e   act;
   logic [1:0] tgt;

   assign act = decode_opcode(chip_mode, cmd_word[19:12]);
   assign tgt = cmd_word[1:0];

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      logic sel_n;
      assign sel_n = cmd_we && (tgt == 2'(n));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chan_on[n] <= 1'b0;
         else if (sel_n && act == CMD_ON)  chan_on[n] <= 1'b1;
         else if (sel_n && act == CMD_OFF) chan_on[n] <= 1'b0;
      end
   end
endmodule

// File: rtl/msc_irq_status.sv
module msc_irq_status #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic [NUM_CH-1:0] tx_evt,
   input  logic [NUM_CH-1:0] rx_evt,
   input  logic [NUM_CH-1:0] report_en,
   output logic [DATA_W-1:0] status_word,
   output logic              irq
);
   import msc_pkg::*;

   logic [NUM_CH-1:0] tx_pend_q, rx_pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_pend_q <= '0;
         rx_pend_q <= '0;
      end else begin
         tx_pend_q <= (clr ? '0 : tx_pend_q) | tx_evt;
         rx_pend_q <= (clr ? '0 : rx_pend_q) | rx_evt;
      end
   end

   always_comb begin
      status_word = '0;
      for (int n = 0; n < NUM_CH; n++) begin
         status_word[n]                = tx_pend_q[n] & report_en[n];
         status_word[RX_STAT_BASE + n] = rx_pend_q[n] & report_en[n];
      end
   end

   assign irq = |status_word;
endmodule

// File: rtl/msc_regfile.sv
module msc_regfile #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned ADDR_W = 14,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned PTR_W  = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_sel,
   input  logic                     bus_we,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [DATA_W-1:0]        bus_wdata,
   output logic [DATA_W-1:0]        bus_rdata,
   input  logic                     chip_mode,
   input  logic [NUM_CH-1:0]        tx_evt,
   input  logic [NUM_CH-1:0]        rx_evt,
   output logic [NUM_CH-1:0]        chan_on,
   output logic [NUM_CH-1:0]        tx_enable,
   output logic [NUM_CH-1:0]        rx_enable,
   output logic [NUM_CH*PTR_W-1:0]  tx_cur_ptr,
   output logic [NUM_CH*PTR_W-1:0]  rx_cur_ptr,
   output logic                     irq
);
   import msc_pkg::*;

   localparam int unsigned MASK_W = 2 * NUM_CH;
   localparam int unsigned WIN_W  = ADDR_W - 8;

   if (NUM_CH < 1 || NUM_CH > 4) begin : g_bad_ch
      $error("msc_regfile: NUM_CH must lie in 1..4");
   end
   if (ADDR_W < 14) begin : g_bad_addr
      $error("msc_regfile: ADDR_W must be at least 14");
   end
   if (DATA_W != BUS_W) begin : g_bad_data
      $error("msc_regfile: DATA_W must be 32");
   end
   if (PTR_W < 1 || PTR_W > DATA_W) begin : g_bad_ptr
      $error("msc_regfile: PTR_W must lie in 1..DATA_W");
   end

   logic              wr_req, rd_req;
   logic              hit_status, hit_mask, hit_cmd, hit_rsp;
   logic [MASK_W-1:0] mask_q;
   logic [DATA_W-1:0] status_word;
   logic [DATA_W-1:0] rd_mux;
   logic [NUM_CH-1:0] win_hit;
   logic [DATA_W-1:0] ch_rd [NUM_CH];

   assign wr_req     = bus_sel && bus_we;
   assign rd_req     = bus_sel && !bus_we;
   assign hit_status = (bus_addr == ADDR_W'(OFS_STATUS));
   assign hit_mask   = (bus_addr == ADDR_W'(OFS_MASK));
   assign hit_cmd    = (bus_addr == ADDR_W'(OFS_CMD));
   assign hit_rsp    = (bus_addr == ADDR_W'(OFS_RSP));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   mask_q <= '0;
      else if (wr_req && hit_mask)  mask_q <= bus_wdata[MASK_W-1:0];
   end

   for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
      assign tx_enable[n] = mask_q[2*n];
      assign rx_enable[n] = mask_q[2*n+1];
      assign win_hit[n]   = (bus_addr[ADDR_W-1:8] == WIN_W'(n + 1));

      msc_chan_regs #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .win_hit (win_hit[n]),
         .wr_en   (wr_req),
         .loc_ofs (bus_addr[7:0]),
         .wdata   (bus_wdata),
         .rd_data (ch_rd[n]),
         .tx_cur  (tx_cur_ptr[n*PTR_W +: PTR_W]),
         .rx_cur  (rx_cur_ptr[n*PTR_W +: PTR_W])
      );
   end

   msc_cmd_ctrl #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_we    (wr_req && hit_cmd),
      .cmd_word  (bus_wdata),
      .chip_mode (chip_mode),
      .chan_on   (chan_on)
   );

   msc_irq_status #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_stat (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (wr_req && hit_status),
      .tx_evt      (tx_evt),
      .rx_evt      (rx_evt),
      .report_en   (tx_enable),
      .status_word (status_word),
      .irq         (irq)
   );

   always_comb begin
      rd_mux = '0;
      if (hit_status)   rd_mux = status_word;
      else if (hit_mask) rd_mux = DATA_W'(mask_q);
      else if (hit_rsp)  rd_mux = RSP_VALUE;
      else begin
         for (int n = 0; n < NUM_CH; n++)
            if (win_hit[n]) rd_mux = ch_rd[n];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (rd_req) bus_rdata <= rd_mux;
   end
endmodule

// File: rtl/msc_regfile_chk.sv
module msc_regfile_chk #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned ADDR_W = 14,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned PTR_W  = 32
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    bus_sel,
   input logic                    bus_we,
   input logic [ADDR_W-1:0]       bus_addr,
   input logic [DATA_W-1:0]       bus_wdata,
   input logic [DATA_W-1:0]       bus_rdata,
   input logic                    chip_mode,
   input logic [NUM_CH-1:0]       tx_evt,
   input logic [NUM_CH-1:0]       rx_evt,
   input logic [NUM_CH-1:0]       chan_on,
   input logic [NUM_CH-1:0]       tx_enable,
   input logic [NUM_CH-1:0]       rx_enable,
   input logic [NUM_CH*PTR_W-1:0] tx_cur_ptr,
   input logic [NUM_CH*PTR_W-1:0] rx_cur_ptr,
   input logic                    irq
);
   logic any_wr;
   assign any_wr = bus_sel && bus_we;

   // R1
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |=> (chan_on == '0 && !irq && tx_enable == '0 && bus_rdata == '0));

   // R8
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (|tx_enable));

   // R7
   clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (any_wr && bus_addr == '0 && tx_evt == '0 && rx_evt == '0) |=> !irq);

   // R6
   pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(tx_evt & tx_enable)) && !bus_sel) |=> irq);

   // R10
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(any_wr && bus_addr == ADDR_W'(14'h2C24)) |=> $stable(chan_on));

   // R4
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !any_wr |=> ($stable(tx_cur_ptr) && $stable(rx_cur_ptr)));

   // R2
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !any_wr |=> ($stable(tx_enable) && $stable(rx_enable)));

   // R11
   rsp_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we && bus_addr == ADDR_W'(14'h2C2C)) |=> bus_rdata == 32'h0000_FFFF);

   // R12
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && !bus_we) |=> $stable(bus_rdata));
endmodule

bind msc_regfile msc_regfile_chk #(
   .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W)
) u_chk (.*);

// File: tb/msc_regfile_tb.sv
module msc_regfile_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_sel = 1'b0, bus_we = 1'b0;
   logic [13:0]  bus_addr = '0;
   logic [31:0]  bus_wdata = '0;
   logic [31:0]  bus_rdata;
   logic         chip_mode = 1'b0;
   logic [3:0]   tx_evt = '0, rx_evt = '0;
   logic [3:0]   chan_on, tx_enable, rx_enable;
   logic [127:0] tx_cur_ptr, rx_cur_ptr;
   logic         irq;

   int checks = 0;
   int failures = 0;

   logic [31:0] m_txs [NCH], m_txe [NCH], m_rxs [NCH], m_rxe [NCH];
   logic [7:0]  m_mask;
   logic [3:0]  m_on, m_tp, m_rp;

   always #(CLK_PERIOD/2) clk = ~clk;

   msc_regfile u_dut (.*);

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_status();
      logic [31:0] s = '0;
      for (int n = 0; n < NCH; n++) begin
         s[n]   = m_tp[n] & m_mask[2*n];
         s[4+n] = m_rp[n] & m_mask[2*n];
      end
      return s;
   endfunction

   function automatic logic [31:0] exp_read(input logic [13:0] a);
      logic [31:0] v = '0;
      int ch;
      if (a == 14'h0) v = exp_status();
      else if (a == 14'h14) v = {24'h0, m_mask};
      else if (a == 14'h2C2C) v = 32'h0000FFFF;
      else if (a[13:8] >= 6'd1 && a[13:8] <= 6'd4) begin
         ch = int'(a[13:8]) - 1;
         case (a[7:0])
            8'h80: v = m_txs[ch];
            8'h84: v = m_txe[ch];
            8'h88: v = m_rxs[ch];
            8'h8C: v = m_rxe[ch];
            default: v = '0;
         endcase
      end
      return v;
   endfunction

   function automatic void model_write(input logic [13:0] a, input logic [31:0] d);
      int ch;
      logic [7:0] op;
      if (a == 14'h0) begin m_tp = '0; m_rp = '0; end
      else if (a == 14'h14) m_mask = d[7:0];
      else if (a == 14'h2C24) begin
         op = d[19:12];
         if (op == 8'h00) m_on[d[1:0]] = 1'b1;
         else if (!chip_mode && op == 8'h10) m_on[d[1:0]] = 1'b0;
         else if (chip_mode && (op == 8'h30 || op == 8'h50)) m_on[d[1:0]] = 1'b0;
      end else if (a[13:8] >= 6'd1 && a[13:8] <= 6'd4) begin
         ch = int'(a[13:8]) - 1;
         case (a[7:0])
            8'h80: m_txs[ch] = d;
            8'h84: m_txe[ch] = d;
            8'h88: m_rxs[ch] = d;
            8'h8C: m_rxe[ch] = d;
            default: ;
         endcase
      end
   endfunction

   // One bus cycle; events may coincide with a write.
   task automatic bus_op(input logic sel, input logic we, input logic [13:0] a,
                         input logic [31:0] d, input logic [3:0] te, input logic [3:0] re);
      @(negedge clk);
      bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = d;
      tx_evt = te; rx_evt = re;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0; tx_evt = '0; rx_evt = '0;
      if (sel && we) model_write(a, d);
      m_tp |= te;
      m_rp |= re;
   endtask

   task automatic wr(input logic [13:0] a, input logic [31:0] d);
      bus_op(1'b1, 1'b1, a, d, 4'h0, 4'h0);
   endtask

   task automatic rd_chk(input string req, input logic [13:0] a);
      bus_op(1'b1, 1'b0, a, 32'h0, 4'h0, 4'h0);
      chk(req, bus_rdata, exp_read(a));
   endtask

   task automatic evt(input logic [3:0] te, input logic [3:0] re);
      bus_op(1'b0, 1'b0, 14'h0, 32'h0, te, re);
   endtask

   task automatic outs_chk(input string req);
      chk({req, " chan_on"}, {28'h0, chan_on}, {28'h0, m_on});
      chk({req, " irq"}, {31'h0, irq}, {31'h0, exp_status() != 0});
      for (int n = 0; n < NCH; n++) begin
         chk({req, " tx_cur"}, tx_cur_ptr[n*32 +: 32], m_txs[n]);
         chk({req, " rx_cur"}, rx_cur_ptr[n*32 +: 32], m_rxs[n]);
         chk({req, " enables"}, {30'h0, rx_enable[n], tx_enable[n]},
             {30'h0, m_mask[2*n+1], m_mask[2*n]});
      end
   endtask

   function automatic logic [13:0] rand_addr();
      logic [13:0] a;
      int ch = int'($urandom_range(1, 4));
      case ($urandom_range(0, 7))
         0: a = 14'h0;
         1: a = 14'h14;
         2: a = 14'h2C2C;
         3: a = 14'h2C24;
         4: a = 14'($urandom_range(0, 16383));
         default: a = {6'(ch), 8'h80 | 8'(4 * $urandom_range(0, 3))};
      endcase
      return a;
   endfunction

   function automatic logic [31:0] rand_cmd();
      logic [7:0] ops [5] = '{8'h00, 8'h10, 8'h30, 8'h50, 8'h20};
      logic [7:0] op = ops[$urandom_range(0, 4)];
      return {12'h0, op, 10'h0, 2'($urandom_range(0, 3))};
   endfunction

   initial begin
      void'($urandom(32'h5EED_0042));
      for (int n = 0; n < NCH; n++) begin
         m_txs[n] = '0; m_txe[n] = '0; m_rxs[n] = '0; m_rxe[n] = '0;
      end
      m_mask = '0; m_on = '0; m_tp = '0; m_rp = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 rdata", bus_rdata, 32'h0);
      outs_chk("R1");
      rst_n = 1'b1;
      rd_chk("R1 status", 14'h0);

      // R2 mask write/readback, upper bits dropped
      wr(14'h14, 32'hFFFF_FFFF);
      rd_chk("R2 mask", 14'h14);
      outs_chk("R2");
      wr(14'h14, 32'h0000_0000);

      // R3 R4 pointers in every window
      for (int n = 0; n < NCH; n++) begin
         wr({6'(n+1), 8'h80}, 32'h1000_0000 + 32'(n*16));
         wr({6'(n+1), 8'h88}, 32'h2000_0000 + 32'(n*16));
         wr({6'(n+1), 8'h84}, 32'h3000_0000 + 32'(n));
         wr({6'(n+1), 8'h8C}, 32'h4000_0000 + 32'(n));
         rd_chk("R3 tx start", {6'(n+1), 8'h80});
         rd_chk("R3 tx end",   {6'(n+1), 8'h84});
         rd_chk("R3 rx start", {6'(n+1), 8'h88});
         rd_chk("R3 rx end",   {6'(n+1), 8'h8C});
         rd_chk("R3 window hole", {6'(n+1), 8'h90});
      end
      outs_chk("R4 cur after start, end writes leave cur");

      // R5 reporting gated by the TX enable bit only
      evt(4'b0101, 4'b1010);
      rd_chk("R5 none enabled", 14'h0);
      wr(14'h14, 32'h0000_00AA);
      rd_chk("R5 rx-only bits", 14'h0);
      outs_chk("R8 irq low with rx-only enables");
      wr(14'h14, 32'h0000_0055);
      rd_chk("R5 tx bits on", 14'h0);
      outs_chk("R8 irq high");
      // R6 sticky across further cycles
      evt(4'b0000, 4'b0000);
      rd_chk("R6 sticky", 14'h0);
      // R7 clear with any data, event coinciding with the clear survives
      bus_op(1'b1, 1'b1, 14'h0, 32'h1234_5678, 4'b0000, 4'b0100);
      rd_chk("R7 clear keeps same-cycle event", 14'h0);
      wr(14'h0, 32'h0);
      rd_chk("R7 cleared", 14'h0);
      outs_chk("R7 irq low");

      // R9 mode 0 dialect
      chip_mode = 1'b0;
      wr(14'h2C24, 32'h0000_0002);
      outs_chk("R9 on ch2");
      wr(14'h2C24, 32'h0003_0002);
      outs_chk("R10 0x30 ignored in mode 0");
      wr(14'h2C24, 32'h0001_0002);
      outs_chk("R9 off ch2");
      // R10 mode 1 dialect
      chip_mode = 1'b1;
      wr(14'h2C24, 32'h0000_0003);
      wr(14'h2C24, 32'h0000_0001);
      wr(14'h2C24, 32'h0001_0003);
      outs_chk("R10 0x10 ignored in mode 1");
      wr(14'h2C24, 32'h0005_0003);
      wr(14'h2C24, 32'h0003_0001);
      outs_chk("R10 0x50 and 0x30 off");

      // R11 R12
      rd_chk("R11 response", 14'h2C2C);
      rd_chk("R11 cmd reads zero", 14'h2C24);
      rd_chk("R12 unmapped", 14'h0048);
      wr(14'h0500, 32'hDEAD_BEEF);
      wr(14'h2C00, 32'hDEAD_BEEF);
      rd_chk("R12 unmapped after write", 14'h2C00);
      for (int n = 0; n < NCH; n++) rd_chk("R12 pointers untouched", {6'(n+1), 8'h80});
      outs_chk("R12 state untouched");
      @(negedge clk);
      chk("R12 rdata holds", bus_rdata, exp_read({6'(NCH), 8'h80}));

      // random phase
      for (int i = 0; i < 600; i++) begin
         logic [13:0] a = rand_addr();
         int kind = int'($urandom_range(0, 9));
         if ($urandom_range(0, 15) == 0) chip_mode = ~chip_mode;
         if (kind < 4) rd_chk("R3 R5 R11 R12 random read", a);
         else if (kind < 7) begin
            if (a == 14'h2C24) wr(a, rand_cmd());
            else wr(a, $urandom());
         end else if (kind == 7) wr(14'h2C24, rand_cmd());
         else bus_op(1'b0, 1'b0, 14'h0, 32'h0, 4'($urandom()), 4'($urandom()));
         if (i % 25 == 0) outs_chk("R4 R6 R8 R10 random outputs");
      end
      outs_chk("R8 final");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule